// File: doc/BRIEF.md
# Lock-Qualified Startup Reset Generator

This block produces the reset for logic that runs on a PLL output clock. Two conditions hold the reset on: the PLL lock indication being low, and an external active-low reset being low. Either condition asserts the output at once, without waiting for a clock edge, and clears an internal cycle counter.

When both conditions have cleared, the counter advances once per PLL clock edge. The output releases on the rising edge that brings the count to `HOLD_CYCLES`. This is how the block waits out a startup interval after the device is configured. The count comes from dividing the wait time by the clock period: for example, a 25 µs wait at 50 MHz needs 1250 cycles. The counter is clocked by the PLL clock, so it also acts as the release synchronizer.

If lock drops or the external reset is pulled low at any point, including part-way through the count, the output reasserts and the full wait runs again from zero. The active level of the output is set by a parameter.

Top module: `rst_gate_counter`

## Requirements
- R1: While `pll_locked` is 0, `rst_out` is at its active level.
- R2: While `ext_rst_n` is 0, `rst_out` is at its active level, whatever the state of `pll_locked`.
- R3: When both inputs become 1 between clock edges, `rst_out` stays active through the first `HOLD_CYCLES`-1 rising edges of `clk_pll`. It goes inactive just after rising edge number `HOLD_CYCLES`, and never between edges.
- R4: Once released, `rst_out` stays inactive for as long as both inputs remain 1.
- R5: If lock is lost part-way through the count, the count restarts from zero. After lock returns, a full `HOLD_CYCLES` edges pass again before release.
- R6: If `ext_rst_n` goes to 0 after release, `rst_out` becomes active at once, with no clock edge needed. After `ext_rst_n` returns to 1, release again takes `HOLD_CYCLES` edges.
- R7: With `OUT_ACTIVE_HIGH`=1 (the default), the active level is 1. With `OUT_ACTIVE_HIGH`=0, the active level is 0 and the timing is the same.
- R8: The counter width is clog2(`HOLD_CYCLES`+1). The count never exceeds `HOLD_CYCLES`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | PLL output clock. Both the count and the release are timed by it. |
| pll_locked | input | 1 | PLL lock indication. 1 means locked. |
| ext_rst_n | input | 1 | External reset, active low. |
| rst_out | output | 1 | Generated reset. Its active level is set by `OUT_ACTIVE_HIGH`. |

## Verification
A counter that is off by one shows up as a release one edge early or one edge late. The bench checks one edge before the expected release and again at the release edge, so this error appears at the port within that one cycle. A counter that is not cleared when lock is lost part-way through the count releases early on the restarted wait. This also shows up within `HOLD_CYCLES` edges. A missing asynchronous path leaves the output inactive between a falling input and the next clock edge. The bench checks that gap directly.

// File: rtl/rgc_pkg.sv
package rgc_pkg;
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rgc_qualify.sv
module rgc_qualify (
  input  logic pll_locked,
  input  logic ext_rst_n,
  output logic hold
);
  // Any disqualifying condition forces the hold path asynchronously.
  assign hold = ~pll_locked | ~ext_rst_n;
endmodule

// File: rtl/rgc_count.sv
module rgc_count #(
  parameter int unsigned HOLD_CYCLES = 1250
) (
  input  logic clk,
  input  logic hold,
  output logic done
);
  import rgc_pkg::*;
  localparam int unsigned W = cnt_width(HOLD_CYCLES);
  localparam logic [W-1:0] LAST = W'(HOLD_CYCLES - 1);
  localparam logic [W-1:0] TOP  = W'(HOLD_CYCLES);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or posedge hold) begin
    if (hold) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (!done) begin
      cnt  <= cnt + 1'b1;
      if (cnt == LAST) done <= 1'b1;
    end
  end

  initial begin
    if (HOLD_CYCLES < 1) $error("HOLD_CYCLES must be at least 1");
  end

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (hold)
    cnt <= TOP);

  // R3
  cnt_step_chk: assert property (@(posedge clk) disable iff (hold)
    !done |=> cnt == $past(cnt) + 1'b1);

  // R3
  done_at_top_chk: assert property (@(posedge clk) disable iff (hold)
    done |-> cnt == TOP);

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (hold)
    done |=> done);

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (hold)
    $past(hold) |-> (cnt == '0 && !done));
endmodule

// File: rtl/rgc_drive.sv
module rgc_drive #(
  parameter bit OUT_ACTIVE_HIGH = 1'b1
) (
  input  logic done,
  output logic rst_out
);
  generate
    if (OUT_ACTIVE_HIGH) begin : g_hi
      assign rst_out = ~done;
    end else begin : g_lo
      assign rst_out = done;
    end
  endgenerate
endmodule

// File: rtl/rst_gate_counter.sv
module rst_gate_counter #(
  parameter int unsigned HOLD_CYCLES     = 1250,
  parameter bit          OUT_ACTIVE_HIGH = 1'b1
) (
  input  logic clk_pll,
  input  logic pll_locked,
  input  logic ext_rst_n,
  output logic rst_out
);
  localparam logic ACT = OUT_ACTIVE_HIGH ? 1'b1 : 1'b0;

  logic hold;
  logic done;

  rgc_qualify u_qual (
    .pll_locked (pll_locked),
    .ext_rst_n  (ext_rst_n),
    .hold       (hold)
  );

  rgc_count #(.HOLD_CYCLES(HOLD_CYCLES)) u_cnt (
    .clk  (clk_pll),
    .hold (hold),
    .done (done)
  );

  rgc_drive #(.OUT_ACTIVE_HIGH(OUT_ACTIVE_HIGH)) u_drv (
    .done    (done),
    .rst_out (rst_out)
  );

  // R1
  lock_hold_chk: assert property (@(posedge clk_pll)
    !pll_locked |-> rst_out == ACT);

  // R2
  ext_hold_chk: assert property (@(posedge clk_pll)
    !ext_rst_n |-> rst_out == ACT);

  // R4
  stay_free_chk: assert property (@(posedge clk_pll) disable iff (hold)
    rst_out != ACT |=> rst_out != ACT);
endmodule

// File: tb/sim_rst_gate_counter.sv
module sim_rst_gate_counter;
  localparam int unsigned N0 = 20;
  localparam int unsigned N1 = 5;

  logic clk = 1'b0;
  logic lk  = 1'b0;
  logic rn  = 1'b1;
  logic out_hi, out_lo;
  int total = 0;
  int bad   = 0;
  bit fin   = 1'b0;

  always #4 clk = ~clk;

  rst_gate_counter #(.HOLD_CYCLES(N0), .OUT_ACTIVE_HIGH(1'b1)) u0 (
    .clk_pll(clk), .pll_locked(lk), .ext_rst_n(rn), .rst_out(out_hi));
  rst_gate_counter #(.HOLD_CYCLES(N1), .OUT_ACTIVE_HIGH(1'b0)) u1 (
    .clk_pll(clk), .pll_locked(lk), .ext_rst_n(rn), .rst_out(out_lo));

  typedef struct packed {
    logic       lk;
    logic       rn;
    logic [7:0] w;
    logic       ex;
    logic [3:0] rq;
  } vec_t;

  localparam vec_t TBL [12] = '{
    '{1'b0, 1'b1, 8'd5,  1'b1, 4'd1},  // R1 no lock
    '{1'b1, 1'b0, 8'd5,  1'b1, 4'd2},  // R2 lock, ext low
    '{1'b1, 1'b1, 8'd19, 1'b1, 4'd3},  // R3 one edge short
    '{1'b1, 1'b1, 8'd1,  1'b0, 4'd3},  // R3 release edge
    '{1'b1, 1'b1, 8'd10, 1'b0, 4'd4},  // R4 stays free
    '{1'b0, 1'b1, 8'd1,  1'b1, 4'd5},  // R5 lock lost
    '{1'b1, 1'b1, 8'd10, 1'b1, 4'd5},  // R5 partial count
    '{1'b0, 1'b1, 8'd2,  1'b1, 4'd5},  // R5 mid-count loss
    '{1'b1, 1'b1, 8'd19, 1'b1, 4'd5},  // R5 restarted count
    '{1'b1, 1'b1, 8'd1,  1'b0, 4'd5},  // R5 release
    '{1'b1, 1'b0, 8'd1,  1'b1, 4'd6},  // R6 ext reset
    '{1'b1, 1'b1, 8'd20, 1'b0, 4'd6}   // R6 full wait again
  };

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #200000;
    if (!fin) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    chk(out_hi, 1'b1, "R1 reset state hi");
    chk(out_lo, 1'b0, "R7 reset state lo");

    for (int i = 0; i < 12; i++) begin
      lk = TBL[i].lk;
      rn = TBL[i].rn;
      repeat (int'(TBL[i].w)) @(posedge clk);
      @(negedge clk);
      chk(out_hi, TBL[i].ex, $sformatf("R%0d vec %0d", TBL[i].rq, i));
    end

    // R6: assertion without a clock edge
    #1 rn = 1'b0;
    #1 chk(out_hi, 1'b1, "R6 async assert");
    chk(out_lo, 1'b0, "R6 async assert lo");
    @(negedge clk);
    rn = 1'b1;

    // R7: active-low instance, N1 edges
    repeat (N1 - 1) @(posedge clk);
    @(negedge clk);
    chk(out_lo, 1'b0, "R7 lo held at N1-1");
    @(posedge clk);
    @(negedge clk);
    chk(out_lo, 1'b1, "R7 lo released at N1");
    chk(out_hi, 1'b1, "R3 hi still held at N1");

    // R2: ext low overrides lock for a long time, then a full wait
    rn = 1'b0;
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(out_hi, 1'b1, "R2 long ext hold");
    rn = 1'b1;
    repeat (N0 - 1) @(posedge clk);
    @(negedge clk);
    chk(out_hi, 1'b1, "R3 count starts at ext release");
    @(posedge clk);
    #1 chk(out_hi, 1'b0, "R3 release right after edge");

    fin = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule